// File: doc/BRIEF.md
# Key-Armed Watchdog Timer with Reset-Out Pulse

This block is a watchdog counter that guards a processor against software upsets. It is dormant after a hardware reset. Software arms it by writing an ordered pair of key bytes to a single write-only service address, and the same pair written again clears the count. Once armed, nothing that software writes can stop it. Only a hardware reset, or the watchdog's own overflow, returns it to the dormant state.

The count advances once per machine cycle. A machine cycle is a fixed number of clocks, produced by a built-in prescaler that the service sequence also clears. When the count passes its all-ones value, the block raises a one-cycle internal reset request. It also drives a reset-out line high for a fixed number of clocks, unless a disable input suppresses that line. Power-state inputs affect counting. Power-down freezes the count. Idle freezes it only when an idle-halt input is set. After a wake-up from power-down on a low interrupt level, counting stays on hold until that line returns high.

Top module: `wdog_keyed`

## Requirements
- R1: After a hardware reset the watchdog is disarmed and both `rst_req` and `rst_out` are low. Without a valid key sequence, they stay low for any length of time.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 as the next write to address 0xA6, arms the watchdog. Writes to other addresses between the two do not break the pair. Any other value written to 0xA6 between the two restarts matching. A repeated 0x1E keeps the first half matched.
- R3: Once armed, `rst_req` pulses high for exactly one cycle. It rises at the clock edge that lies PRESCALE × 2^CNT_W clocks after the edge that accepted the last service write. With the default parameters this is 12 × 16384 clocks.
- R4: A second valid key sequence, written while armed, clears the counter and prescaler. The overflow is then due a full period after the new service edge.
- R5: While armed, writes that do not complete the key sequence neither disarm the watchdog nor change its count. An overflow disarms it, so no further overflow follows without a new key sequence.
- R6: When `rstout_dis` is 0 at the overflow edge, `rst_out` goes high in the same cycle as `rst_req` and stays high for exactly PULSE_LEN (98) clocks.
- R7: When `rstout_dis` is 1 at the overflow edge, `rst_req` still pulses but `rst_out` stays low.
- R8: While `idle` and `idle_halt` are both 1, the count and prescaler hold. The overflow is delayed by exactly the number of such cycles.
- R9: While `idle` is 1 and `idle_halt` is 0, counting continues, and the overflow time is unchanged.
- R10: While `pdown` is 1, the count and prescaler hold.
- R11: If `wake_irq_n` is low while `pdown` is 1, counting stays held after `pdown` falls. It resumes in the first cycle in which `wake_irq_n` is high.
- R12: A hardware reset during armed counting disarms the watchdog, and no overflow follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rstout_dis | input | 1 | 1 suppresses the reset-out pulse |
| idle_halt | input | 1 | 1 holds the count while idle |
| idle | input | 1 | Core is in idle mode |
| pdown | input | 1 | Core is in power-down mode |
| wake_irq_n | input | 1 | Wake-up interrupt level, active low |
| rst_req | output | 1 | One-cycle internal reset request on overflow |
| rst_out | output | 1 | Reset-out drive, high for PULSE_LEN clocks |

## Verification
The service edge is the clock edge that samples the second key write. Both `rst_req` and `rst_out` rise after the edge that lies PRESCALE × 2^CNT_W clocks past the service edge, plus one clock for each cycle held by idle, power-down or the wake hold. `rst_out` falls PULSE_LEN clocks after it rises. The bench counts clock edges from the service edge and samples on the falling edge. For each overflow it checks the cycle before the due edge (still low), the due edge (high), the last cycle of the pulse and the cycle after it. Each overflow is therefore pinned to an exact cycle, not to a window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    KEY_WAIT_FIRST = 1'b0,
    KEY_WAIT_SECOND = 1'b1
  } key_state_e;

  // Clocks from a service edge to the overflow edge.
  function automatic int unsigned wdog_period(input int unsigned cnt_w,
                                              input int unsigned prescale);
    return prescale << cnt_w;
  endfunction

  // Next state of the key matcher after a write to the service address.
  function automatic key_state_e key_next(input key_state_e st,
                                          input logic is_first_key);
    return is_first_key ? KEY_WAIT_SECOND : KEY_WAIT_FIRST;
  endfunction

endpackage

// File: rtl/wdog_key_match.sv
module wdog_key_match
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              svc_hit
);

  key_state_e st_q;
  logic       svc_wr;

  assign svc_wr  = wr_en && (wr_addr == SVC_ADDR);
  assign svc_hit = svc_wr && (st_q == KEY_WAIT_SECOND) && (wr_data == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KEY_WAIT_FIRST;
    end else if (svc_wr) begin
      st_q <= key_next(st_q, wr_data == KEY_A);
    end
  end

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned PRESCALE = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             ovf
);

  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (pre_q == PRE_LAST);
  assign ovf  = tick && (cnt_q == CNT_MAX) && !clr;
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int unsigned PULSE_LEN = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);

  localparam int unsigned LEN_W = $clog2(PULSE_LEN + 1);
  localparam logic [LEN_W-1:0] LEN_LOAD = LEN_W'(PULSE_LEN);

  logic [LEN_W-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= LEN_LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned PRESCALE = 12,
  parameter int unsigned PULSE_LEN = 98,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rstout_dis,
  input  logic              idle_halt,
  input  logic              idle,
  input  logic              pdown,
  input  logic              wake_irq_n,
  output logic              rst_req,
  output logic              rst_out
);

  logic             svc_hit;
  logic             armed_q;
  logic             wake_hold_q;
  logic             hold_wake;
  logic             hold_idle;
  logic             run;
  logic             tick;
  logic             ovf;
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  wdog_key_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .svc_hit(svc_hit)
  );

  // Wake hold: armed by a low interrupt level during power-down,
  // released as soon as the line is seen high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_hold_q <= 1'b0;
    end else if (pdown && !wake_irq_n) begin
      wake_hold_q <= 1'b1;
    end else if (wake_irq_n) begin
      wake_hold_q <= 1'b0;
    end
  end

  assign hold_wake = wake_hold_q && !wake_irq_n;
  assign hold_idle = idle && idle_halt;
  assign run       = armed_q && !pdown && !hold_wake && !hold_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (svc_hit) begin
      armed_q <= 1'b1;
    end else if (ovf) begin
      armed_q <= 1'b0;
    end
  end

  wdog_tick_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(svc_hit), .run(run),
    .cnt(cnt_q), .tick(tick), .ovf(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= ovf;
    end
  end

  assign rst_req = req_q;

  wdog_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(ovf && !rstout_dis), .active(rst_out)
  );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rstout_dis,
  input logic             idle,
  input logic             idle_halt,
  input logic             pdown,
  input logic             svc_hit,
  input logic             ovf,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_req,
  input logic             rst_out
);

  // R3: request lasts one cycle
  p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R2: completed key pair arms
  p_key_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |=> armed);

  // R4: service clears the count
  p_svc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hit |=> (cnt == '0));

  // R5: only an overflow or reset leaves the armed state
  p_armed_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ovf) |=> armed);

  // R6: reset-out only rises together with a request
  p_out_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> rst_req);

  // R7: disabled reset-out stays low on overflow
  p_out_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && rstout_dis && !rst_out) |=> !rst_out);

  // R8: idle with halt holds the count
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_halt && !svc_hit) |=> $stable(cnt));

  // R10: power-down freezes the count
  p_pdown_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !svc_hit) |=> $stable(cnt));

endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rstout_dis(rstout_dis), .idle(idle),
  .idle_halt(idle_halt), .pdown(pdown), .svc_hit(svc_hit), .ovf(ovf),
  .armed(armed_q), .cnt(cnt_q), .rst_req(rst_req), .rst_out(rst_out)
);

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
  import wdog_pkg::*;

  localparam int unsigned TB_CNT_W = 6;
  localparam int unsigned TB_PRE = 12;
  localparam int unsigned TB_PULSE = 98;
  localparam int N = 12 * 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       rstout_dis = 1'b0;
  logic       idle_halt = 1'b0;
  logic       idle = 1'b0;
  logic       pdown = 1'b0;
  logic       wake_irq_n = 1'b1;
  logic       rst_req;
  logic       rst_out;

  int n_chk = 0;
  int n_bad = 0;
  int req_seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_keyed #(.CNT_W(TB_CNT_W), .PRESCALE(TB_PRE), .PULSE_LEN(TB_PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rstout_dis(rstout_dis), .idle_halt(idle_halt),
    .idle(idle), .pdown(pdown), .wake_irq_n(wake_irq_n),
    .rst_req(rst_req), .rst_out(rst_out)
  );

  always @(negedge clk) if (rst_req) req_seen++;

  // Vector: {addr1,data1,addr2,data2,addr3,data3,slot}; slot = write index
  // that completes the key pair (0 = none).
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {8'hA6, 8'h1E, 8'hA6, 8'hE1, 8'h00, 8'h00, 2'd2},
    {8'hA6, 8'h1E, 8'h55, 8'hE1, 8'hA6, 8'hE1, 2'd3},
    {8'hA6, 8'h1E, 8'hA6, 8'h00, 8'hA6, 8'hE1, 2'd0},
    {8'hA6, 8'hE1, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 2'd3},
    {8'hA6, 8'h1E, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 2'd3},
    {8'hA7, 8'h1E, 8'hA7, 8'hE1, 8'hA6, 8'hE1, 2'd0},
    {8'hA6, 8'hE1, 8'hA6, 8'hE1, 8'hA6, 8'h1E, 2'd0},
    {8'h00, 8'h00, 8'hA6, 8'h1E, 8'hA6, 8'hE1, 2'd3}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Service pair on back-to-back edges; returns after the service edge.
  task automatic service();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'hA6; wr_data = 8'h1E;
    @(negedge clk);
    wr_data = 8'hE1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Overflow expected 'rem' edges from now.
  task automatic ovf_check(input string tag, input int rem, input logic pulse);
    edges(rem - 1);
    check({tag, " req early"}, rst_req, 1'b0);
    edges(1);
    check({tag, " req due"}, rst_req, 1'b1);
    check({tag, " out due"}, rst_out, pulse);
    edges(TB_PULSE - 1);
    check({tag, " out last"}, rst_out, pulse);
    edges(1);
    check({tag, " out end"}, rst_out, 1'b0);
    edges(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    edges(3);
    check("R1 reset req", rst_req, 1'b0);
    check("R1 reset out", rst_out, 1'b0);
    rst_n = 1'b1;
    base = req_seen;
    edges(N + 50);
    check("R1 no req while dormant", logic'(req_seen == base), 1'b1);
    check("R1 out low while dormant", rst_out, 1'b0);

    // R2 key sequences from the vector table
    for (int v = 0; v < NV; v++) begin
      logic [49:0] e;
      e = VEC[v];
      @(negedge clk);
      wr_en = 1'b1; wr_addr = e[49:42]; wr_data = e[41:34];
      @(negedge clk);
      wr_addr = e[33:26]; wr_data = e[25:18];
      @(negedge clk);
      wr_addr = e[17:10]; wr_data = e[9:2];
      @(negedge clk);
      wr_en = 1'b0;
      edges(N - 2);
      check($sformatf("R2 vec%0d edge-2", v), rst_req, 1'b0);
      edges(1);
      check($sformatf("R2 R3 vec%0d edge-1", v), rst_req, logic'(e[1:0] == 2'd2));
      edges(1);
      check($sformatf("R2 R3 vec%0d edge0", v), rst_req, logic'(e[1:0] == 2'd3));
      edges(TB_PULSE + 5);
    end

    // R3 R6 full period and pulse width, using the package period
    service();
    ovf_check("R3 R6 period", int'(wdog_period(TB_CNT_W, TB_PRE)), 1'b1);

    // R5 overflow disarms
    base = req_seen;
    edges(N + 50);
    check("R5 no second overflow", logic'(req_seen == base), 1'b1);

    // R4 re-service restarts the period
    service();
    edges(500);
    service();
    ovf_check("R4 reservice", N, 1'b1);

    // R5 non-key writes change nothing
    service();
    wr1(8'hA6, 8'h00);
    wr1(8'hA6, 8'hFF);
    wr1(8'hA6, 8'hE1);
    ovf_check("R5 stray writes", N - 6, 1'b1);

    // R7 reset-out disabled
    rstout_dis = 1'b1;
    service();
    ovf_check("R7 out masked", N, 1'b0);
    rstout_dis = 1'b0;

    // R8 idle with halt delays by 37
    service();
    idle_halt = 1'b1; idle = 1'b1;
    edges(37);
    idle = 1'b0;
    ovf_check("R8 idle halt", N, 1'b1);

    // R9 idle without halt does not delay
    idle_halt = 1'b0;
    service();
    idle = 1'b1;
    edges(40);
    idle = 1'b0;
    ovf_check("R9 idle run", N - 40, 1'b1);

    // R10 power-down freeze of 53 cycles
    service();
    pdown = 1'b1;
    edges(53);
    pdown = 1'b0;
    ovf_check("R10 pdown", N, 1'b1);

    // R11 wake hold: 20 in power-down, 31 more with interrupt low
    service();
    pdown = 1'b1; wake_irq_n = 1'b0;
    edges(20);
    pdown = 1'b0;
    edges(31);
    wake_irq_n = 1'b1;
    ovf_check("R11 wake hold", N, 1'b1);

    // R12 hardware reset disarms
    service();
    edges(10);
    rst_n = 1'b0;
    edges(2);
    rst_n = 1'b1;
    base = req_seen;
    edges(N + 50);
    check("R12 no overflow after reset", logic'(req_seen == base), 1'b1);
    check("R12 out low after reset", rst_out, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule